// File: doc/BRIEF.md
# NAND Page/Block Operation Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus and turns a single request into a full bus transaction. A request carries an operation code (page read, page program or block erase), a 17-bit page address and a 10-bit start column within a 528-byte page. The sequencer then produces the bus cycles in order. Command bytes go out with the command-latch line high, address bytes with the address-latch line high, and data bytes with both low. For a read, it picks the pointer command from the column region. It waits on the ready/busy line, and it streams the data bytes to or from the host side.

Program and erase end with a status poll. Once the device reports ready on the ready/busy line, the sequencer sends the status command and reads one status byte. If that byte says the device is still busy, it reads the status again. If the device stays busy for longer than a configurable number of clocks, the sequencer sends the reset command and reports a timeout. Every write-strobe and read-strobe pulse is held low and high for a configurable minimum number of clocks.

The host hands over requests with a valid/ready handshake. It supplies program bytes on a take-pulse interface and receives read bytes with a valid pulse. Each request ends with a one-cycle done pulse and a 2-bit result code.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset the bus is idle: write and read strobes high, both latch enables low, data output enable low, reqReady high, done low.
- R2: A request is taken on a clock where reqValid and reqReady are both high. reqReady then stays low until the operation ends, and done is a single-cycle pulse that comes with the result.
- R3: Every command cycle has command-latch high and address-latch low. Every address cycle has address-latch high and command-latch low. Every data cycle has both low. The two latch enables are never high together.
- R4: Read and program start with a pointer command chosen from the start column: 0x00 for columns 0..255, 0x01 for 256..511, 0x50 for 512..527. Four address cycles follow, in this order: the column byte (column bits 7..0), page bits 7..0, page bits 15..8, and page bit 16 placed in bit 0 with the other bits zero.
- R5: A read does not pulse the read strobe before ready/busy (high = ready) has returned high after the last address cycle. It then returns 528 minus the start column bytes, in column order, each with one rdValid pulse. The result is 0 (pass).
- R6: A program sends, after the pointer command, 0x80, the four address cycles, then 528 minus the start column data bytes taken in order from progData (one progTake pulse per byte), then 0x10.
- R7: An erase sends 0x60, three address cycles holding the page bytes (no column byte), then 0xD0.
- R8: After program or erase, once ready/busy is high, 0x70 is sent and a status byte is read. If status bit 6 is 1, the result is 0 (pass) when bit 0 is 0 and 1 (fail) when bit 0 is 1. If bit 6 is 0, the status byte is read again without sending a new command.
- R9: Each write-strobe or read-strobe low pulse lasts at least STROBE_LO clocks. The strobes are high together for at least STROBE_HI clocks between pulses, and never low together.
- R10: If ready/busy stays low, or status bit 6 stays 0, for BUSY_LIMIT clocks, the command 0xFF is sent and the result is 2 (timeout).
- R11: A program request that follows a failed program repeats the complete sequence: pointer command, 0x80, the address cycles and every data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle and able to accept a request |
| reqOp | input | 2 | Operation: 0 read, 1 program, 2 erase (3 is treated as read) |
| reqPage | input | PAGE_W | Page address (page-in-block in bits 4..0, block above) |
| reqCol | input | COL_W | Start column, 0..527 |
| progData | input | 8 | Next program byte |
| progTake | output | 1 | Pulse: current progData byte has been consumed |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | Pulse: rdData holds the next read byte |
| done | output | 1 | Pulse: operation finished |
| result | output | 2 | 0 pass, 1 fail, 2 timeout (valid with done) |
| nandCle | output | 1 | Command-latch enable |
| nandAle | output | 1 | Address-latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Bus byte driven to the device |
| nandDoe | output | 1 | Bus output enable |
| nandDin | input | 8 | Bus byte from the device |
| nandRbN | input | 1 | Ready/busy, high when ready |

## Verification
Reads are run at start columns on each side of the 255/256 and 511/512 borders and at column 527. These cases separate the three pointer commands and check that the byte count shrinks to a single byte. Programs and erases are run against a device model whose status reports pass or fail, and which can also report busy in the status byte for a few reads. This checks that the result comes from bit 0 only when bit 6 says ready, and that a program after a failure is sent again in full. Busy periods longer than the limit check the reset command and the timeout code. Random mixes of operation, page, column, busy length and outcome check the full bus transcript and the strobe widths across many combinations.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    RES_PASS    = 2'd0,
    RES_FAIL    = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_e;

  // One bus cycle request from control to datapath
  typedef struct packed {
    logic       start;   // begin a strobe cycle this clock
    logic       rd;      // read strobe cycle (else write strobe)
    logic       cle;     // command latch level for the cycle
    logic       ale;     // address latch level for the cycle
    logic       toHost;  // read byte goes to the host stream
    logic [7:0] wbyte;   // byte driven in a write cycle
  } cyc_t;

  localparam logic [7:0] CMD_PTR_A   = 8'h00;
  localparam logic [7:0] CMD_PTR_B   = 8'h01;
  localparam logic [7:0] CMD_PTR_C   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h80;
  localparam logic [7:0] CMD_PROG_GO = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO= 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

endpackage

// File: rtl/nseq_dpath.sv
module nseq_dpath
  import nseq_pkg::*;
#(
  parameter int STROBE_LO = 2,
  parameter int STROBE_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cyc_t       cyc,
  output logic       cycDone,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] nandDout,
  output logic       nandDoe,
  input  logic [7:0] nandDin,
  output logic [7:0] rdByte,
  output logic       rdValid
);

  localparam int MAXW = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
  localparam int CW   = $clog2(MAXW + 1);

  logic          act;
  logic          lowPh;
  logic          isRd;
  logic          toHost;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      lowPh    <= 1'b0;
      isRd     <= 1'b0;
      toHost   <= 1'b0;
      cnt      <= '0;
      cycDone  <= 1'b0;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      nandReN  <= 1'b1;
      nandDout <= 8'h00;
      nandDoe  <= 1'b0;
      rdByte   <= 8'h00;
      rdValid  <= 1'b0;
    end else begin
      cycDone <= 1'b0;
      rdValid <= 1'b0;
      if (!act) begin
        if (cyc.start) begin
          act      <= 1'b1;
          lowPh    <= 1'b1;
          cnt      <= '0;
          isRd     <= cyc.rd;
          toHost   <= cyc.toHost;
          nandCle  <= cyc.cle;
          nandAle  <= cyc.ale;
          nandDout <= cyc.wbyte;
          nandDoe  <= !cyc.rd;
          nandWeN  <= cyc.rd;
          nandReN  <= !cyc.rd;
        end
      end else if (lowPh) begin
        if (cnt == CW'(STROBE_LO - 1)) begin
          lowPh   <= 1'b0;
          cnt     <= '0;
          nandWeN <= 1'b1;
          nandReN <= 1'b1;
          if (isRd) begin
            rdByte  <= nandDin;
            rdValid <= toHost;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == CW'(STROBE_HI - 1)) begin
          act     <= 1'b0;
          cycDone <= 1'b1;
          nandCle <= 1'b0;
          nandAle <= 1'b0;
          nandDoe <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // Run-length counters for strobe width checks
  logic [7:0] lowRun;
  logic [7:0] hiRun;
  logic       anyLow;
  assign anyLow = !nandWeN || !nandReN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowRun <= 8'd0;
      hiRun  <= 8'hFF;
    end else begin
      lowRun <= anyLow  ? ((lowRun == 8'hFF) ? lowRun : lowRun + 8'd1) : 8'd0;
      hiRun  <= !anyLow ? ((hiRun  == 8'hFF) ? hiRun  : hiRun  + 8'd1) : 8'd0;
    end
  end

  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nandCle && nandAle));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nandWeN && !nandReN));

  // R9
  strobe_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(!anyLow) |-> (lowRun >= 8'(STROBE_LO)));

  // R9
  strobe_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(anyLow) |-> (hiRun >= 8'(STROBE_HI)));

endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_W     = 17,
  parameter int COL_W      = 10,
  parameter int BUSY_LIMIT = 5000,
  parameter int WB_GUARD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [7:0]        progData,
  output logic              progTake,
  input  logic              nandRbN,
  output cyc_t              cyc,
  input  logic              cycDone,
  input  logic              statReady,
  input  logic              statFail,
  output logic              done,
  output logic [1:0]        result
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int TMR_W = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PTR, S_OPC, S_ADDR, S_WAIT, S_DATA,
    S_ENDC, S_STC, S_STR, S_RST, S_FIN
  } st_e;

  st_e               st;
  op_e               op;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic              pend;
  logic [1:0]        idx;
  logic [CNT_W-1:0]  left;
  logic [TMR_W-1:0]  tmr;
  res_e              res;

  logic        issue;
  logic        tmrHit;
  logic        guardOk;
  logic [23:0] pageX;
  logic [7:0]  ptrCmd;
  logic [7:0]  addrByte;

  assign pageX   = 24'(page);
  assign tmrHit  = (tmr >= TMR_W'(BUSY_LIMIT));
  assign guardOk = (tmr >= TMR_W'(WB_GUARD));
  assign reqReady = (st == S_IDLE);

  always_comb begin
    if (int'(col) < 256)      ptrCmd = CMD_PTR_A;
    else if (int'(col) < 512) ptrCmd = CMD_PTR_B;
    else                      ptrCmd = CMD_PTR_C;
  end

  always_comb begin
    case (idx)
      2'd0:    addrByte = col[7:0];
      2'd1:    addrByte = pageX[7:0];
      2'd2:    addrByte = pageX[15:8];
      default: addrByte = pageX[23:16];
    endcase
  end

  always_comb begin
    issue = !pend && (st inside {S_PTR, S_OPC, S_ADDR, S_DATA,
                                 S_ENDC, S_STC, S_STR, S_RST});
    cyc = '0;
    cyc.start = issue;
    case (st)
      S_PTR:  begin cyc.cle = 1'b1; cyc.wbyte = ptrCmd; end
      S_OPC:  begin cyc.cle = 1'b1; cyc.wbyte = (op == OP_PROG) ? CMD_PROG : CMD_ERASE; end
      S_ADDR: begin cyc.ale = 1'b1; cyc.wbyte = addrByte; end
      S_DATA: begin
        if (op == OP_READ) begin cyc.rd = 1'b1; cyc.toHost = 1'b1; end
        else cyc.wbyte = progData;
      end
      S_ENDC: begin cyc.cle = 1'b1; cyc.wbyte = (op == OP_PROG) ? CMD_PROG_GO : CMD_ERASE_GO; end
      S_STC:  begin cyc.cle = 1'b1; cyc.wbyte = CMD_STATUS; end
      S_STR:  cyc.rd = 1'b1;
      S_RST:  begin cyc.cle = 1'b1; cyc.wbyte = CMD_RESET; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op       <= OP_READ;
      page     <= '0;
      col      <= '0;
      pend     <= 1'b0;
      idx      <= 2'd0;
      left     <= '0;
      tmr      <= '0;
      res      <= RES_PASS;
      done     <= 1'b0;
      result   <= 2'd0;
      progTake <= 1'b0;
    end else begin
      done     <= 1'b0;
      progTake <= issue && (st == S_DATA) && (op == OP_PROG);
      if (issue) pend <= 1'b1;
      if ((st == S_WAIT || st == S_STR) && !tmrHit) tmr <= tmr + 1'b1;
      case (st)
        S_IDLE: begin
          if (reqValid) begin
            op   <= (reqOp == 2'd3) ? OP_READ : op_e'(reqOp);
            page <= reqPage;
            col  <= reqCol;
            left <= CNT_W'(PAGE_BYTES) - CNT_W'(reqCol);
            idx  <= 2'd0;
            res  <= RES_PASS;
            st   <= (reqOp == 2'd2) ? S_OPC : S_PTR;
          end
        end
        S_WAIT: begin
          if (guardOk && nandRbN) st <= (op == OP_READ) ? S_DATA : S_STC;
          else if (tmrHit)        st <= S_RST;
        end
        S_FIN: begin
          done   <= 1'b1;
          result <= res;
          st     <= S_IDLE;
        end
        default: begin
          if (pend && cycDone) begin
            pend <= 1'b0;
            case (st)
              S_PTR: begin
                idx <= 2'd0;
                st  <= (op == OP_PROG) ? S_OPC : S_ADDR;
              end
              S_OPC: begin
                idx <= (op == OP_ERASE) ? 2'd1 : 2'd0;
                st  <= S_ADDR;
              end
              S_ADDR: begin
                if (idx == 2'd3) begin
                  tmr <= '0;
                  if (op == OP_READ)      st <= S_WAIT;
                  else if (op == OP_PROG) st <= S_DATA;
                  else                    st <= S_ENDC;
                end else begin
                  idx <= idx + 2'd1;
                end
              end
              S_DATA: begin
                left <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                  if (op == OP_READ) st <= S_FIN;
                  else               st <= S_ENDC;
                end
              end
              S_ENDC: begin
                tmr <= '0;
                st  <= S_WAIT;
              end
              S_STC: begin
                tmr <= '0;
                st  <= S_STR;
              end
              S_STR: begin
                if (statReady) begin
                  res <= statFail ? RES_FAIL : RES_PASS;
                  st  <= S_FIN;
                end else if (tmrHit) begin
                  st <= S_RST;
                end
              end
              S_RST: begin
                res <= RES_TIMEOUT;
                st  <= S_FIN;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  read_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc.start && st == S_DATA && op == OP_READ) |-> nandRbN);

  // R10
  reset_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc.start && cyc.cle && cyc.wbyte == CMD_RESET) |-> tmrHit);

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_W     = 17,
  parameter int COL_W      = $clog2(PAGE_BYTES),
  parameter int STROBE_LO  = 2,
  parameter int STROBE_HI  = 2,
  parameter int BUSY_LIMIT = 5000,
  parameter int WB_GUARD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [7:0]        progData,
  output logic              progTake,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              done,
  output logic [1:0]        result,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDout,
  output logic              nandDoe,
  input  logic [7:0]        nandDin,
  input  logic              nandRbN
);

  cyc_t cyc;
  logic cycDone;

  nseq_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .BUSY_LIMIT(BUSY_LIMIT), .WB_GUARD(WB_GUARD)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqPage(reqPage), .reqCol(reqCol),
    .progData(progData), .progTake(progTake),
    .nandRbN(nandRbN), .cyc(cyc), .cycDone(cycDone),
    .statReady(rdData[6]), .statFail(rdData[0]),
    .done(done), .result(result)
  );

  nseq_dpath #(
    .STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)
  ) uDpath (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .cycDone(cycDone),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .rdByte(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/sim_nand_op_sequencer.sv
module sim_nand_op_sequencer;

  localparam int PB = 528;
  localparam int LO = 2;
  localparam int HI = 3;
  localparam int LIM = 300;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'd0;
  logic [16:0] reqPage = '0;
  logic [9:0]  reqCol = '0;
  logic [7:0]  progData;
  logic        progTake;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        done;
  logic [1:0]  result;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin;
  logic        nandRbN;

  nand_op_sequencer #(
    .PAGE_BYTES(PB), .PAGE_W(17), .STROBE_LO(LO), .STROBE_HI(HI),
    .BUSY_LIMIT(LIM), .WB_GUARD(GUARD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqPage(reqPage), .reqCol(reqCol),
    .progData(progData), .progTake(progTake), .rdData(rdData),
    .rdValid(rdValid), .done(done), .result(result),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRbN(nandRbN)
  );

  int nChk = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdPat(input int p);
    return 8'((p * 13 + 90) & 255);
  endfunction

  function automatic logic [7:0] progPat(input int i, input int tag);
    return 8'((i * 5 + tag) & 255);
  endfunction

  // ---------------- device model ----------------
  int          busyKnob = 10;
  bit          failKnob = 0;
  int          sbKnob = 0;
  int          busyCnt = 0;
  int          statBusy = 0;
  bit          statMode = 0;
  int          ptr = 0;
  int          base = 0;
  int          addrCnt = 0;
  logic [7:0]  lastCmd = 8'h00;
  logic        pWe = 1'b1, pRe = 1'b1;
  int          evN = 0;
  logic [1:0]  evT [0:1023];
  logic [7:0]  evB [0:1023];
  int          statReads = 0;
  bit          reWhileBusy = 0;

  assign nandRbN = (busyCnt == 0);
  assign nandDin = statMode ? {1'b1, (busyCnt == 0 && statBusy == 0), 5'b0, failKnob}
                            : rdPat(ptr);

  always @(posedge clk) begin
    pWe <= nandWeN;
    pRe <= nandReN;
    busyCnt <= (busyCnt > 0) ? busyCnt - 1 : 0;
    if (nandWeN && !pWe) begin
      evT[evN] <= nandCle ? 2'd0 : (nandAle ? 2'd1 : 2'd2);
      evB[evN] <= nandDout;
      evN <= evN + 1;
      if (nandCle) begin
        lastCmd <= nandDout;
        statMode <= (nandDout == 8'h70);
        addrCnt <= 0;
        if (nandDout == 8'h70) statBusy <= sbKnob;
        if (nandDout == 8'h10 || nandDout == 8'hD0) busyCnt <= busyKnob;
        if (nandDout == 8'hFF) busyCnt <= 0;
        if (nandDout == 8'h00) base <= 0;
        if (nandDout == 8'h01) base <= 256;
        if (nandDout == 8'h50) base <= 512;
      end else if (nandAle) begin
        addrCnt <= addrCnt + 1;
        if (addrCnt == 0) ptr <= base + int'(nandDout);
        if (addrCnt == 3 && (lastCmd == 8'h00 || lastCmd == 8'h01 || lastCmd == 8'h50))
          busyCnt <= busyKnob;
      end else begin
        ptr <= ptr + 1;
      end
    end
    if (nandReN && !pRe) begin
      if (statMode) begin
        statReads <= statReads + 1;
        if (statBusy > 0) statBusy <= statBusy - 1;
      end else ptr <= ptr + 1;
    end
    if (!nandReN && pRe && busyCnt > 0) reWhileBusy <= 1'b1;
  end

  // strobe width monitor
  int minLow = 1000, minHigh = 1000, run = 0;
  logic pStb = 1'b1;
  bit seenLow = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if ((nandWeN & nandReN) == pStb) run = run + 1;
      else begin
        if (!pStb) begin
          if (run < minLow) minLow = run;
          seenLow = 1;
        end else if (seenLow && run < minHigh) minHigh = run;
        run = 1;
      end
      pStb = nandWeN & nandReN;
    end
  end

  // ---------------- expected transcript ----------------
  int         xN;
  logic [1:0] xT [0:1023];
  logic [7:0] xB [0:1023];
  int         progIdx;
  int         progTag;
  int         rdN;
  logic [7:0] rdGot [0:1023];

  assign progData = progPat(progIdx, progTag);

  task automatic push(input int t, input int b);
    xT[xN] = 2'(t);
    xB[xN] = 8'(b);
    xN++;
  endtask

  function automatic int ptrFor(input int c);
    if (c >= 512) return 'h50;
    if (c >= 256) return 'h01;
    return 'h00;
  endfunction

  task automatic doOp(input int opc, input int pg, input int cl, input int bl,
                      input bit fl, input int sb, input string tagReq);
    int n;
    bit to;
    bit gotDone;
    int gotRes;
    int firstBad;
    int nb;
    int expRes;
    string reqS;
    to = (bl > LIM);
    busyKnob = bl; failKnob = fl; sbKnob = sb;
    progIdx = 0; progTag = (pg + cl) & 255; rdN = 0;
    @(negedge clk);
    evN = 0; statReads = 0; reWhileBusy = 0;
    reqValid = 1'b1; reqOp = 2'(opc); reqPage = 17'(pg); reqCol = 10'(cl);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R2", "reqReady low after accept", int'(reqReady), 0);
    n = 0; gotDone = 0; gotRes = 0;
    while (!gotDone && n < 60000) begin
      @(negedge clk);
      n++;
      if (progTake) progIdx++;
      if (rdValid) begin rdGot[rdN] = rdData; rdN++; end
      if (done) begin gotDone = 1; gotRes = int'(result); end
    end
    chk(gotDone, "R2", "operation finished", int'(gotDone), 1);
    @(negedge clk);
    chk(done == 1'b0 && reqReady == 1'b1, "R2", "done single pulse, ready back",
        int'(done), 0);

    xN = 0;
    if (opc != 2) push(0, ptrFor(cl));
    if (opc == 1) push(0, 'h80);
    if (opc == 2) push(0, 'h60);
    if (opc != 2) push(1, cl & 255);
    push(1, pg & 255);
    push(1, (pg >> 8) & 255);
    push(1, (pg >> 16) & 1);
    if (opc == 1) begin
      for (int i = 0; i < PB - cl; i++) push(2, progPat(i, progTag));
      push(0, 'h10);
    end
    if (opc == 2) push(0, 'hD0);
    if (to) push(0, 'hFF);
    else if (opc != 0) push(0, 'h70);

    firstBad = -1;
    for (int i = 0; i < xN && i < evN; i++)
      if (firstBad < 0 && (evT[i] != xT[i] || evB[i] != xB[i])) firstBad = i;
    reqS = (opc == 0) ? "R4" : ((opc == 1) ? "R6" : "R7");
    chk(evN == xN, reqS, {tagReq, " bus cycle count"}, evN, xN);
    chk(firstBad < 0, (opc == 2) ? "R7" : "R3", {tagReq, " bus byte/latch at index"},
        firstBad < 0 ? 0 : int'(evB[firstBad]), firstBad < 0 ? 0 : int'(xB[firstBad]));

    expRes = to ? 2 : ((opc == 0) ? 0 : int'(fl));
    chk(gotRes == expRes, to ? "R10" : ((opc == 0) ? "R5" : "R8"),
        {tagReq, " result code"}, gotRes, expRes);

    if (opc == 0 && !to) begin
      nb = 0;
      for (int i = 0; i < rdN; i++) if (rdGot[i] != rdPat(cl + i)) nb++;
      chk(rdN == PB - cl, "R5", {tagReq, " read byte count"}, rdN, PB - cl);
      chk(nb == 0, "R5", {tagReq, " read byte mismatches"}, nb, 0);
      chk(!reWhileBusy, "R5", {tagReq, " read strobe while busy"}, int'(reWhileBusy), 0);
    end
    if (opc != 0 && !to)
      chk(statReads == sb + 1, "R8", {tagReq, " status reads"}, statReads, sb + 1);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(nandWeN && nandReN && !nandCle && !nandAle && !nandDoe && reqReady && !done,
        "R1", "idle bus during reset", int'({nandWeN, nandReN, nandCle, nandAle, nandDoe}), 24);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(nandWeN && nandReN && !nandCle && !nandAle && !nandDoe && reqReady && !done,
        "R1", "idle bus after reset", int'({nandWeN, nandReN, nandCle, nandAle, nandDoe}), 24);

    // pointer regions and boundaries (R4, R5)
    doOp(0, 'h1ABCD, 0,   20, 0, 0, "read c0");
    doOp(0, 'h00321, 255, 15, 0, 0, "read c255");
    doOp(0, 'h10001, 256, 15, 0, 0, "read c256");
    doOp(0, 'h0F0F0, 511, 15, 0, 0, "read c511");
    doOp(0, 'h12345, 512, 15, 0, 0, "read c512");
    doOp(0, 'h1FFFF, 527, 15, 0, 0, "read c527");
    // program fail then full retry (R6, R8, R11)
    doOp(1, 'h04567, 0, 30, 1, 0, "prog fail");
    doOp(1, 'h04567, 0, 30, 0, 0, "R11 prog retry");
    doOp(1, 'h00042, 300, 25, 0, 0, "prog c300");
    // erase (R7)
    doOp(2, 'h1FFFF, 0, 40, 0, 0, "erase pass");
    doOp(2, 'h0ABCD, 0, 40, 1, 0, "erase fail");
    // status still busy (R8)
    doOp(1, 'h00777, 520, 10, 0, 2, "prog status busy");
    // timeouts (R10)
    doOp(0, 'h00888, 10, 2000, 0, 0, "read timeout");
    doOp(2, 'h00999, 0, 2000, 0, 0, "erase timeout");
    // random mix
    for (int k = 0; k < 10; k++) begin
      int o, p, c, b, s;
      bit f;
      o = int'($urandom % 3);
      p = int'($urandom % 131072);
      c = int'($urandom % 528);
      b = 5 + int'($urandom % 80);
      f = 1'($urandom % 2);
      s = int'($urandom % 3);
      doOp(o, p, c, b, f, s, "random");
    end

    // R9 strobe widths observed at the bus
    chk(minLow >= LO, "R9", "min strobe low clocks", minLow, LO);
    chk(minHigh >= HI, "R9", "min strobe high clocks", minHigh, HI);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule